// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block decides whether a memory address issued on the processor side belongs to one of the outbound windows that are passed on to the PCI bus. The region from 0xF000_0000 upward is split into 8 MiB chunks. Chunk i, for i from 1 to 30, is a candidate window. A window forwards only when two things are true: the global forwarding gate is open, and the window's bit in the window-enable register is set.

Two registers are written through a one-cycle write port. The I/O control register holds the two-bit gate code. The window-enable register holds one bit per chunk. The gate is a two-state machine. It is GATE_CLOSED out of reset. A control write whose bits [8:7] are 2'b01 takes it to GATE_OPEN, and a control write with any other code takes it back to GATE_CLOSED. A write to the enable register leaves the gate state unchanged.

The decode from request address to hit, window index and forwarded address is purely combinational.

Top module: `outwin_decoder`

## Requirements
- R1: After reset both registers read back as zero, and no address produces a hit.
- R2: A write with `wr_sel`=0 loads the control register and a write with `wr_sel`=1 loads the window-enable register. The register chosen by `rd_sel` (0 = control, 1 = enable) returns all 32 bits exactly as written.
- R3: Forwarding is open only while bits [8:7] of the control register equal 2'b01. With any other code in those bits, no address hits, whatever the enable register holds.
- R4: Window i (1 to 30) covers 0xF000_0000 + i×0x80_0000 through that base + 0x7F_FFFF. An address in that range hits when the gate is open and enable bit i is set, and `win_idx` then equals i.
- R5: Enable bit 0 and enable bit 31 never cause a hit, even when they are set and the gate is open.
- R6: An address below 0xF080_0000 or above 0xFF7F_FFFF never hits.
- R7: `hit`, `win_idx` and `fwd_addr` follow `req_addr` in the same cycle. `fwd_addr` always equals `req_addr`.
- R8: A register write changes the decode from the clock edge that captures it, so a request in the very next cycle already sees the new value.
- R9: While `hit` is 0, `win_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control, 1 = window enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Readback select: 0 = control, 1 = window enable |
| rd_data | output | 32 | Readback of the selected register |
| req_addr | input | 32 | Request address on the processor side |
| hit | output | 1 | Address falls in an enabled window |
| win_idx | output | 5 | Index of the matched window, 0 when there is no hit |
| fwd_addr | output | 32 | Address to forward, equal to the request address |

## Verification
Every window is probed at both its first and its last byte. This separates correct chunk boundaries from off-by-one slicing of the address. The gate code is swept through all four values of bits [8:7], and toggling only the neighbouring bits 6 and 9 exposes a field taken from the wrong position. Enable patterns include a single bit, alternating bits, and all ones. With all ones set, the two reserved chunks at 0xF000_0000 and 0xFF80_0000 must still miss, which catches a decoder that honours enable bit 0 or bit 31. Requests issued on the cycle right after a write show whether the decode waits on an extra register stage.

// File: rtl/outwin_pkg.sv
package outwin_pkg;
    localparam int ADDR_W     = 32;
    localparam int CHUNK_LOG2 = 23;
    localparam int IDX_W      = 5;
    localparam int NUM_CHUNKS = 1 << IDX_W;
    localparam int TAG_W      = ADDR_W - IDX_W - CHUNK_LOG2;
    localparam logic [TAG_W-1:0] REGION_TAG = 4'hF;
    localparam int GATE_LSB   = 7;
    localparam logic [1:0] GATE_OPEN_CODE = 2'b01;

    typedef enum logic { SEL_CTRL = 1'b0, SEL_WINEN = 1'b1 } reg_sel_e;
    typedef enum logic { GATE_CLOSED = 1'b0, GATE_OPEN = 1'b1 } gate_e;
endpackage

// File: rtl/outwin_regs.sv
module outwin_regs
    import outwin_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] en_q,
    output logic          gate_open
);
    gate_e state_q, state_d;
    reg_sel_e sel;

    assign sel = reg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CTRL) ctrl_q <= wr_data;
            else                 en_q   <= wr_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_CLOSED:
                if (wr_en && sel == SEL_CTRL &&
                    wr_data[GATE_LSB +: 2] == GATE_OPEN_CODE)
                    state_d = GATE_OPEN;
            GATE_OPEN:
                if (wr_en && sel == SEL_CTRL &&
                    wr_data[GATE_LSB +: 2] != GATE_OPEN_CODE)
                    state_d = GATE_CLOSED;
            default: state_d = GATE_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            GATE_OPEN:   gate_open = 1'b1;
            GATE_CLOSED: gate_open = 1'b0;
            default:     gate_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/outwin_match.sv
module outwin_match
    import outwin_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int CL2   = CHUNK_LOG2,
    parameter int IW    = IDX_W,
    parameter int NCH   = NUM_CHUNKS
) (
    input  logic [AW-1:0]  addr,
    input  logic [NCH-1:0] en_mask,
    input  logic           gate_open,
    output logic           any_hit,
    output logic [IW-1:0]  idx
);
    localparam int TW = AW - IW - CL2;

    logic [TW-1:0]  tag;
    logic [IW-1:0]  chunk;
    logic           in_region;
    logic [NCH-1:0] match;

    assign tag       = addr[AW-1 -: TW];
    assign chunk     = addr[CL2 +: IW];
    assign in_region = (tag == TW'(REGION_TAG));

    // Chunk 0 and the last chunk are never forwarded.
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_win
            if (g == 0 || g == NCH - 1) begin : g_reserved
                assign match[g] = 1'b0;
            end else begin : g_live
                assign match[g] = gate_open && in_region &&
                                  (chunk == IW'(g)) && en_mask[g];
            end
        end
    endgenerate

    assign any_hit = |match;

    always_comb begin
        idx = '0;
        for (int k = 0; k < NCH; k++) begin
            if (match[k]) idx = idx | IW'(k);
        end
    end
endmodule

// File: rtl/outwin_decoder.sv
module outwin_decoder
    import outwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [ADDR_W-1:0]   wr_data,
    input  logic                rd_sel,
    output logic [ADDR_W-1:0]   rd_data,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                hit,
    output logic [IDX_W-1:0]    win_idx,
    output logic [ADDR_W-1:0]   fwd_addr
);
    logic [ADDR_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] en_q;
    logic              gate_open;

    outwin_regs #(.DW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctrl_q    (ctrl_q),
        .en_q      (en_q),
        .gate_open (gate_open)
    );

    outwin_match #(
        .AW  (ADDR_W),
        .CL2 (CHUNK_LOG2),
        .IW  (IDX_W),
        .NCH (NUM_CHUNKS)
    ) u_match (
        .addr      (req_addr),
        .en_mask   (en_q[NUM_CHUNKS-1:0]),
        .gate_open (gate_open),
        .any_hit   (hit),
        .idx       (win_idx)
    );

    assign fwd_addr = req_addr;
    assign rd_data  = (reg_sel_e'(rd_sel) == SEL_WINEN) ? en_q : ctrl_q;
endmodule

// File: rtl/outwin_checker.sv
module outwin_checker
    import outwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [ADDR_W-1:0] wr_data,
    input logic [ADDR_W-1:0] req_addr,
    input logic              hit,
    input logic [IDX_W-1:0]  win_idx,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic [ADDR_W-1:0] ctrl_q,
    input logic [ADDR_W-1:0] en_q
);
    a_r3_gate_code: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ctrl_q[GATE_LSB +: 2] == GATE_OPEN_CODE);

    a_r3_closed_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[GATE_LSB +: 2] != GATE_OPEN_CODE) |=> !hit);

    a_r4_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> en_q[win_idx] && req_addr[CHUNK_LOG2 +: IDX_W] == win_idx);

    a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> win_idx != '0 && win_idx != '1);

    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> req_addr >= 32'hF080_0000 && req_addr <= 32'hFF7F_FFFF);

    a_r7_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_addr == req_addr);

    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> ctrl_q == $past(wr_data));

    a_r2_en_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> en_q == $past(wr_data));

    a_r9_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> win_idx == '0);
endmodule

bind outwin_decoder outwin_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .req_addr (req_addr),
    .hit      (hit),
    .win_idx  (win_idx),
    .fwd_addr (fwd_addr),
    .ctrl_q   (ctrl_q),
    .en_q     (en_q)
);

// File: tb/tb_outwin_decoder.sv
module tb_outwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_sel, rd_sel;
    logic [31:0] wr_data, rd_data, req_addr, fwd_addr;
    logic        hit;
    logic [4:0]  win_idx;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_ctrl, m_en;

    always #2 clk = ~clk;

    outwin_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .req_addr(req_addr), .hit(hit), .win_idx(win_idx), .fwd_addr(fwd_addr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_en = d; else m_ctrl = d;
    endtask

    // Expected decode derived from the requirements.
    task automatic probe(string req, logic [31:0] a);
        logic [4:0] c;
        logic       e_hit;
        req_addr = a;
        #1;
        c = a[27:23];
        e_hit = (a[31:28] == 4'hF) && c != 5'd0 && c != 5'd31 &&
                m_en[c] && m_ctrl[8:7] == 2'b01;
        chk(req, {31'd0, hit}, {31'd0, e_hit});
        chk(req, {27'd0, win_idx}, e_hit ? {27'd0, c} : 32'd0);
        chk("R7", fwd_addr, a);
    endtask

    task automatic t_reset();
        rd_sel = 1'b0; #1; chk("R1", rd_data, 32'd0);
        rd_sel = 1'b1; #1; chk("R1", rd_data, 32'd0);
        probe("R1", 32'hF080_0000);
        probe("R1", 32'hF800_0000);
    endtask

    task automatic t_readback();
        wr(1'b0, 32'hA5A5_5A5A);
        wr(1'b1, 32'h8000_0001);
        rd_sel = 1'b0; #1; chk("R2", rd_data, 32'hA5A5_5A5A);
        rd_sel = 1'b1; #1; chk("R2", rd_data, 32'h8000_0001);
    endtask

    task automatic t_codes();
        wr(1'b1, 32'hFFFF_FFFF);
        for (int k = 0; k < 4; k++) begin
            wr(1'b0, 32'(k) << 7);
            probe("R3", 32'hF100_0000);
        end
        wr(1'b0, 32'h0000_0240);  // neighbours set, code 00
        probe("R3", 32'hF100_0000);
        wr(1'b0, 32'h0000_02C0);  // code 01 with neighbours
        probe("R3", 32'hF100_0000);
    endtask

    task automatic t_windows();
        wr(1'b0, 32'h0000_0080);
        wr(1'b1, 32'hFFFF_FFFF);
        for (int i = 1; i < 31; i++) begin
            probe("R4", 32'hF000_0000 + (32'(i) << 23));
            probe("R4", 32'hF000_0000 + (32'(i) << 23) + 32'h007F_FFFF);
        end
        wr(1'b1, 32'h5555_5554);
        for (int i = 1; i < 31; i++)
            probe("R4", 32'hF000_0000 + (32'(i) << 23) + 32'h0004_0000);
    endtask

    task automatic t_edges();
        wr(1'b1, 32'hFFFF_FFFF);
        probe("R5", 32'hF000_0000);
        probe("R5", 32'hF07F_FFFF);
        probe("R5", 32'hFF80_0000);
        probe("R5", 32'hFFFF_FFFF);
        probe("R6", 32'hEF80_0000);
        probe("R6", 32'h0080_0000);
        probe("R6", 32'h7000_0000);
    endtask

    task automatic t_immediate();
        wr(1'b1, 32'h0000_0004);
        probe("R8", 32'hF100_0000);
        wr(1'b1, 32'h0000_0000);
        probe("R8", 32'hF100_0000);
        wr(1'b1, 32'h0000_0004);
        wr(1'b0, 32'h0000_0000);
        probe("R8", 32'hF100_0000);
        probe("R9", 32'hF180_0000);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        rd_sel = 1'b0; req_addr = '0; m_ctrl = '0; m_en = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_codes();
        t_windows();
        t_edges();
        t_immediate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule